// File: doc/BRIEF.md
# Cross-Domain Control Register Bank with Per-Register Busy Flags

This block holds a small bank of control registers. Software writes them from a fast core clock, and they are used by peripheral logic that runs on a slow low-frequency clock with no fixed phase or ratio to the core clock. A write strobe with an address and data goes into a per-register staging flop. For each register, a toggle request crosses into the low-frequency domain, where a shadow copy is loaded after a fixed number of low-frequency edges. A toggle acknowledge then crosses back. While the transfer is under way, that register's busy bit is set in a status word that the core can read. Software does not need to wait for the busy bit: a launched transfer finishes with no further core activity.

Some registers can be built as immediate registers through a parameter mask. These bypass the crossing: the peripheral-side value changes at the core write edge and their busy bit never rises. A core-domain freeze input lets software stage several registers without launching them. When freeze drops, every staged register is launched on the same core edge, so all of them land on the same low-frequency edge. A write to a register whose busy bit is set is dropped and reported with a one-cycle error pulse.

Top module: `lf_write_sync`

## Requirements
- R1: While rstN is low, and right after it is released, busyStatus is all zero, writeError is 0 and every lfRegs field is 0.
- R2: An accepted write to a delayed register (one whose IMM_MASK bit is 0) sets busyStatus bit [wrAddr] on the same coreClk edge that captures the data.
- R3: For a write launched at a coreClk edge, the lfRegs field of that register keeps its old value through the first two lfClk rising edges after that edge and holds the new value after the third.
- R4: The busy bit stays set until after the lfRegs field has been updated. It then clears by itself with no further write, and the value stays in place.
- R5: A write to a register whose busy bit is set is ignored, so the earlier value is the one that arrives. writeError is 1 for exactly the one coreClk cycle that follows the edge where the write was presented.
- R6: A register whose IMM_MASK bit is 1 (register 3 by default) shows the written data on lfRegs right after the capture edge, and its busy bit never rises.
- R7: While freeze is 1, writes to delayed registers are captured and set their busy bits, but no lfRegs field changes, however many lfClk edges pass.
- R8: On the first coreClk edge with freeze at 0, every staged register launches together with any write presented on that same edge. All of them update on the same third lfClk edge.
- R9: Registers are independent. Writes to different delayed registers on consecutive core cycles both set their busy bits and both deliver their own values.
- The lfRegs field of register i sits at bits [i*DATA_W +: DATA_W], and busyStatus bit i belongs to register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coreClk | input | 1 | Fast core clock |
| lfClk | input | 1 | Slow low-frequency peripheral clock, asynchronous to coreClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write strobe, sampled on coreClk |
| wrAddr | input | ADDR_W | Register index of the write |
| wrData | input | DATA_W | Write data |
| freeze | input | 1 | Holds staged writes back from launching while high |
| busyStatus | output | NUM_REGS | Per-register transfer-in-progress flags, core domain |
| writeError | output | 1 | One-cycle pulse after a write to a busy register |
| lfRegs | output | NUM_REGS*DATA_W | Peripheral-side register values, packed by index |

## Verification
Two functions can fall on the same core edge: the freeze release that launches staged registers, and a brand-new write to another register. The bench stages two registers under freeze, then drops freeze and presents a write to a third register in the same cycle. All three busy bits must be set after that edge. All three lfRegs fields must still hold their old values after the second lfClk edge and their new values after the third. A write that hits a register still in flight is a second case: the bench checks the error pulse and confirms that only the first value arrives.

// File: rtl/lf_write_sync_pkg.sv
package lf_write_sync_pkg;

  // Per-register strobes from control to datapath
  typedef struct packed {
    logic stageLoad;  // capture wrData into the staging flop of a delayed register
    logic immLoad;    // capture wrData straight into an immediate register
  } regStrobe_t;

endpackage

// File: rtl/lf_write_sync_ctrl.sv
module lf_write_sync_ctrl
  import lf_write_sync_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W = 2,
  parameter logic [NUM_REGS-1:0] IMM_MASK = '0
) (
  input  logic                          coreClk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic                          freeze,
  input  logic [NUM_REGS-1:0]           ackTog,
  output regStrobe_t [NUM_REGS-1:0]     strobes,
  output logic [NUM_REGS-1:0]           reqTog,
  output logic [NUM_REGS-1:0]           busyStatus,
  output logic                          writeError
);

  localparam logic [NUM_REGS-1:0] DLY_MASK = ~IMM_MASK;

  logic [NUM_REGS-1:0] hit, busyNow, acceptDly, rejectHit, launch;
  logic [NUM_REGS-1:0] pendingQ, pendingD, reqTogQ, ackMeta, ackSync;
  logic                writeErrQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign hit[i]               = wrEn && (wrAddr == ADDR_W'(i));
    assign strobes[i].stageLoad = acceptDly[i];
    assign strobes[i].immLoad   = hit[i] & IMM_MASK[i];
  end

  // Busy while staged-but-frozen, or while a request toggle is unanswered
  assign busyNow   = pendingQ | (reqTogQ ^ ackSync);
  assign acceptDly = hit & ~busyNow & DLY_MASK;
  assign rejectHit = hit & busyNow;
  assign launch    = freeze ? '0 : (acceptDly | pendingQ);
  assign pendingD  = freeze ? (pendingQ | acceptDly) : '0;

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      reqTogQ   <= '0;
      pendingQ  <= '0;
      ackMeta   <= '0;
      ackSync   <= '0;
      writeErrQ <= 1'b0;
    end else begin
      reqTogQ   <= reqTogQ ^ launch;
      pendingQ  <= pendingD;
      ackMeta   <= ackTog;
      ackSync   <= ackMeta;
      writeErrQ <= |rejectHit;
    end
  end

  assign reqTog     = reqTogQ;
  assign busyStatus = busyNow;
  assign writeError = writeErrQ;

endmodule

// File: rtl/lf_write_sync_dp.sv
module lf_write_sync_dp
  import lf_write_sync_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W = 8,
  parameter logic [NUM_REGS-1:0] IMM_MASK = '0
) (
  input  logic                         coreClk,
  input  logic                         lfClk,
  input  logic                         rstN,
  input  regStrobe_t [NUM_REGS-1:0]    strobes,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [NUM_REGS-1:0]          reqTog,
  output logic [NUM_REGS-1:0]          ackTog,
  output logic [NUM_REGS*DATA_W-1:0]   lfRegs
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (IMM_MASK[i]) begin : g_imm
      logic [DATA_W-1:0] immQ;
      logic              unusedDly;
      assign unusedDly = reqTog[i] ^ strobes[i].stageLoad;

      always_ff @(posedge coreClk or negedge rstN) begin
        if (!rstN)                   immQ <= '0;
        else if (strobes[i].immLoad) immQ <= wrData;
      end

      assign lfRegs[i*DATA_W +: DATA_W] = immQ;
      assign ackTog[i] = 1'b0;
    end else begin : g_dly
      logic [DATA_W-1:0] stageQ, shadowQ;
      logic              reqMeta, reqSync, seenQ;
      logic              unusedImm;
      assign unusedImm = strobes[i].immLoad;

      // Core side: staging holds still until the acknowledge returns
      always_ff @(posedge coreClk or negedge rstN) begin
        if (!rstN)                     stageQ <= '0;
        else if (strobes[i].stageLoad) stageQ <= wrData;
      end

      // LF side: two sync flops, then load on the third edge
      always_ff @(posedge lfClk or negedge rstN) begin
        if (!rstN) begin
          reqMeta <= 1'b0;
          reqSync <= 1'b0;
          seenQ   <= 1'b0;
          shadowQ <= '0;
        end else begin
          reqMeta <= reqTog[i];
          reqSync <= reqMeta;
          if (reqSync != seenQ) begin
            shadowQ <= stageQ;
            seenQ   <= reqSync;
          end
        end
      end

      assign lfRegs[i*DATA_W +: DATA_W] = shadowQ;
      assign ackTog[i] = seenQ;
    end
  end

endmodule

// File: rtl/lf_write_sync.sv
module lf_write_sync
  import lf_write_sync_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W = 8,
  parameter logic [NUM_REGS-1:0] IMM_MASK = 4'b1000,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                        coreClk,
  input  logic                        lfClk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        freeze,
  output logic [NUM_REGS-1:0]         busyStatus,
  output logic                        writeError,
  output logic [NUM_REGS*DATA_W-1:0]  lfRegs
);

  regStrobe_t [NUM_REGS-1:0] strobes;
  logic [NUM_REGS-1:0]       reqTog, ackTog;

  lf_write_sync_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IMM_MASK(IMM_MASK)
  ) u_ctrl (
    .coreClk(coreClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .freeze(freeze), .ackTog(ackTog), .strobes(strobes), .reqTog(reqTog),
    .busyStatus(busyStatus), .writeError(writeError)
  );

  lf_write_sync_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IMM_MASK(IMM_MASK)
  ) u_dp (
    .coreClk(coreClk), .lfClk(lfClk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .reqTog(reqTog), .ackTog(ackTog), .lfRegs(lfRegs)
  );

endmodule

// File: rtl/lf_write_sync_chk.sv
module lf_write_sync_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [NUM_REGS-1:0] IMM_MASK = '0
) (
  input logic                        coreClk,
  input logic                        lfClk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic [ADDR_W-1:0]           wrAddr,
  input logic [DATA_W-1:0]           wrData,
  input logic [NUM_REGS-1:0]         busyStatus,
  input logic                        writeError,
  input logic [NUM_REGS*DATA_W-1:0]  lfRegs
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    if (IMM_MASK[i]) begin : g_imm
      // R6
      imm_update_chk: assert property (@(posedge coreClk) disable iff (!rstN)
        (wrEn && wrAddr == ADDR_W'(i)) |=> (lfRegs[i*DATA_W +: DATA_W] == $past(wrData)));
    end else begin : g_dly
      // R2
      busy_set_chk: assert property (@(posedge coreClk) disable iff (!rstN)
        (wrEn && wrAddr == ADDR_W'(i) && !busyStatus[i]) |=> busyStatus[i]);
      // R5
      reject_flag_chk: assert property (@(posedge coreClk) disable iff (!rstN)
        (wrEn && wrAddr == ADDR_W'(i) && busyStatus[i]) |=> writeError);
      // R4
      shadow_busy_chk: assert property (@(posedge lfClk) disable iff (!rstN)
        !$stable(lfRegs[i*DATA_W +: DATA_W]) |-> $past(busyStatus[i]));
    end
  end

endmodule

bind lf_write_sync lf_write_sync_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_MASK(IMM_MASK)
) u_chk (.*);

// File: tb/lf_write_sync_bench.sv
`timescale 1ns/100ps
module lf_write_sync_bench;
  localparam int NR = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  logic coreClk = 1'b0, lfClk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, freeze = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NR-1:0] busyStatus;
  logic          writeError;
  logic [NR*DW-1:0] lfRegs;

  int checks = 0, fails = 0, lfEdges = 0, startEdge = 0;
  bit done = 1'b0;

  lf_write_sync #(.NUM_REGS(NR), .DATA_W(DW), .IMM_MASK(4'b1000)) u_lf_write_sync (
    .coreClk(coreClk), .lfClk(lfClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .freeze(freeze), .busyStatus(busyStatus),
    .writeError(writeError), .lfRegs(lfRegs)
  );

  always #5 coreClk = ~coreClk;
  initial begin
    #7.3;
    forever begin lfClk = 1'b1; #36.5; lfClk = 1'b0; #36.5; end
  end
  always @(posedge lfClk) lfEdges <= lfEdges + 1;

  function automatic logic [DW-1:0] regVal(input int i);
    return lfRegs[i*DW +: DW];
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d);
    @(negedge coreClk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(posedge coreClk);
    startEdge = lfEdges;
    #1 wrEn = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    for (int k = 0; k < 100; k++) begin
      @(negedge coreClk);
      if (busyStatus == '0) break;
    end
    checkEq(tag, 32'(busyStatus), 32'h0);
  endtask

  task automatic testReset();
    checkEq("R1 busy in reset", 32'(busyStatus), 0);
    checkEq("R1 error in reset", 32'(writeError), 0);
    checkEq("R1 regs in reset", lfRegs, 0);
    #102 rstN = 1'b1;
    repeat (2) @(negedge coreClk);
    checkEq("R1 busy after reset", 32'(busyStatus), 0);
    checkEq("R1 regs after reset", lfRegs, 0);
  endtask

  task automatic testLatency();
    doWrite(0, 8'h5A);
    checkEq("R2 busy bit0 set at capture", 32'(busyStatus[0]), 1);
    checkEq("R3 reg0 old at capture", 32'(regVal(0)), 0);
    wait (lfEdges >= startEdge + 2); #1;
    checkEq("R3 reg0 old after two lf edges", 32'(regVal(0)), 0);
    wait (lfEdges >= startEdge + 3); #1;
    checkEq("R3 reg0 new after third lf edge", 32'(regVal(0)), 32'h5A);
    checkEq("R4 busy still set when copy lands", 32'(busyStatus[0]), 1);
    waitIdle("R4 busy clears on its own");
    checkEq("R4 reg0 kept", 32'(regVal(0)), 32'h5A);
  endtask

  task automatic testImmediate();
    doWrite(3, 8'hC3);
    checkEq("R6 imm reg updated at capture", 32'(regVal(3)), 32'hC3);
    checkEq("R6 imm busy low", 32'(busyStatus), 0);
    repeat (3) @(negedge coreClk);
    checkEq("R6 imm busy stays low", 32'(busyStatus), 0);
  endtask

  task automatic testReject();
    doWrite(1, 8'h11);
    doWrite(1, 8'h22);
    checkEq("R5 error pulse", 32'(writeError), 1);
    @(posedge coreClk); #1;
    checkEq("R5 error one cycle only", 32'(writeError), 0);
    waitIdle("R5 busy clears");
    checkEq("R5 rejected data ignored", 32'(regVal(1)), 32'h11);
    doWrite(1, 8'h33);
    checkEq("R5 error low on legal write", 32'(writeError), 0);
    waitIdle("R5 busy clears again");
    checkEq("R5 later write accepted", 32'(regVal(1)), 32'h33);
  endtask

  task automatic testFreeze();
    int l;
    @(negedge coreClk) freeze = 1'b1;
    doWrite(0, 8'hA1);
    doWrite(1, 8'hB2);
    checkEq("R7 busy set while frozen", 32'(busyStatus[1:0]), 3);
    l = lfEdges;
    wait (lfEdges >= l + 6); #1;
    checkEq("R7 reg0 held", 32'(regVal(0)), 32'h5A);
    checkEq("R7 reg1 held", 32'(regVal(1)), 32'h33);
    checkEq("R7 busy held", 32'(busyStatus[1:0]), 3);
    // Release and a new write on the same edge
    @(negedge coreClk);
    freeze = 1'b0; wrEn = 1'b1; wrAddr = AW'(2); wrData = 8'hC4;
    @(posedge coreClk);
    startEdge = lfEdges;
    #1 wrEn = 1'b0;
    checkEq("R8 busy for all three", 32'(busyStatus[2:0]), 7);
    wait (lfEdges >= startEdge + 2); #1;
    checkEq("R8 all old after two edges", 32'({regVal(2), regVal(1), regVal(0)}), 32'h00335A);
    wait (lfEdges >= startEdge + 3); #1;
    checkEq("R8 all new on third edge", 32'({regVal(2), regVal(1), regVal(0)}), 32'hC4B2A1);
    waitIdle("R8 busy clears");
  endtask

  task automatic testIndependent();
    doWrite(0, 8'h0F);
    doWrite(2, 8'hF0);
    checkEq("R9 both busy", 32'({busyStatus[2], busyStatus[0]}), 3);
    waitIdle("R9 busy clears");
    checkEq("R9 reg0", 32'(regVal(0)), 32'h0F);
    checkEq("R9 reg2", 32'(regVal(2)), 32'hF0);
    checkEq("R9 others untouched", 32'({regVal(3), regVal(1)}), 32'hC3B2);
  endtask

  initial begin
    testReset();
    testLatency();
    testImmediate();
    testReject();
    testFreeze();
    testIndependent();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule